// File: doc/BRIEF.md
# Microcoded Multi-Cycle Control Sequencer

This block drives the control lines of a multi-cycle processor datapath from a constant control store rather than from hand-written state logic. A micro-address register selects one control word per clock. Each word carries the datapath control fields and ends with a two-bit sequencing field. That field picks the next micro-address: the next word in order, the entry a dispatch table gives for the current opcode, or the fetch word at micro-address 0.

Every instruction starts with a fetch word and then a decode word. The decode word dispatches on the opcode to the first word of that instruction's execute sequence. The last word of each sequence returns to fetch. The step counts match a hard-wired multi-cycle controller. The pins are plain control pins with no valid/ready handshake. The opcode needs to be stable only during the decode cycle. It is never back-pressured and is read at no other time.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the outputs show the fetch word: alu_op=00, alu_src_a=0, alu_src_b=00, mem_op=01, wb_sel=00, pc_upd=01, ir_load=1.
- R2: The cycle after every fetch word shows the decode word: alu_op=00, alu_src_a=0, alu_src_b=11, mem_op=00, wb_sel=00, pc_upd=00, ir_load=0.
- R3: Opcode 6'h00 (register ALU op) runs 4 cycles. Step 3 has alu_op=10, alu_src_a=1, alu_src_b=01. Step 4 has wb_sel=01. All other fields are zero.
- R4: Opcode 6'h0D (OR immediate) runs 4 cycles. Step 3 has alu_op=11, alu_src_a=1, alu_src_b=10. Step 4 has wb_sel=10.
- R5: Opcode 6'h23 (load) runs 5 cycles. Step 3 has alu_op=00, alu_src_a=1, alu_src_b=10. Step 4 has mem_op=10. Step 5 has wb_sel=11.
- R6: Opcode 6'h2B (store) runs 4 cycles. Step 3 matches the load address step. Step 4 has mem_op=11.
- R7: Opcode 6'h04 (branch if equal) runs 3 cycles. Step 3 has alu_op=01, alu_src_a=1, alu_src_b=01, pc_upd=10.
- R8: Opcode 6'h02 (jump) runs 4 cycles. Step 3 has alu_src_b=11. Step 4 has pc_upd=11.
- R9: An opcode that is not in the dispatch table returns to fetch straight after decode, giving 2 cycles.
- R10: The opcode is read only in the decode cycle. A change in any other cycle does not alter the running sequence.
- R11: Lowering `rst_n` in the middle of a sequence forces the fetch word at once.
- R12: The field codes are fixed as follows. alu_op: 00 add, 01 subtract, 10 function field, 11 OR. alu_src_b: 00 constant four, 01 register B, 10 immediate, 11 shifted immediate. mem_op: 00 none, 01 fetch, 10 read, 11 write. wb_sel: 00 none, 01 ALU to rd, 10 ALU to rt, 11 memory to rt. pc_upd: 00 hold, 01 ALU, 10 conditional, 11 target. A sequencing code of 11 acts as go-to-fetch, and ir_load is only ever high together with mem_op=01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the held instruction |
| alu_op | output | 2 | ALU operation select |
| alu_src_a | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU B operand select |
| mem_op | output | 2 | Shared memory access field |
| wb_sel | output | 2 | Shared register write-back field |
| pc_upd | output | 2 | PC update select |
| ir_load | output | 1 | Instruction register load |

## Verification
The control word depends only on the micro-address register through the combinational store. A new word is therefore due in the same cycle that follows each rising edge, and it stays in place until the next edge. The driver changes the opcode and reset 1 ns after a rising edge. It queues one expected word per cycle of the instruction. A monitor pops and compares one word at each falling edge, so each word is checked in the cycle it is due. The mid-sequence reset is compared at the falling edge after reset drops, because it acts at once without waiting for a clock.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UA_W  = 4;
  localparam int OP_W  = 6;
  localparam int N_DSP = 6;

  typedef logic [UA_W-1:0] uaddr_t;
  typedef logic [OP_W-1:0] opc_t;

  typedef enum logic [1:0] {ALU_ADD = 2'b00, ALU_SUB = 2'b01, ALU_FN = 2'b10, ALU_OR = 2'b11} alu_e;
  typedef enum logic [1:0] {SB_FOUR = 2'b00, SB_REGB = 2'b01, SB_IMM = 2'b10, SB_IMMSH = 2'b11} srcb_e;
  typedef enum logic [1:0] {MO_NONE = 2'b00, MO_FETCH = 2'b01, MO_READ = 2'b10, MO_WRITE = 2'b11} mem_e;
  typedef enum logic [1:0] {WB_NONE = 2'b00, WB_ALU_RD = 2'b01, WB_ALU_RT = 2'b10, WB_MEM_RT = 2'b11} wb_e;
  typedef enum logic [1:0] {PC_HOLD = 2'b00, PC_ALU = 2'b01, PC_COND = 2'b10, PC_TGT = 2'b11} pcu_e;
  typedef enum logic [1:0] {SQ_INC = 2'b00, SQ_DISP = 2'b01, SQ_FETCH = 2'b10, SQ_RSVD = 2'b11} seq_e;

  // Datapath fields first, sequencing field last.
  typedef struct packed {
    alu_e  alu_op;
    logic  src_a;
    srcb_e src_b;
    mem_e  mem_op;
    wb_e   wb_sel;
    pcu_e  pc_upd;
    logic  ir_load;
    seq_e  seq;
  } uword_t;

  localparam uaddr_t UA_FETCH  = 4'd0;
  localparam uaddr_t UA_DECODE = 4'd1;
  localparam uaddr_t UA_RX     = 4'd2;
  localparam uaddr_t UA_RW     = 4'd3;
  localparam uaddr_t UA_OX     = 4'd4;
  localparam uaddr_t UA_OW     = 4'd5;
  localparam uaddr_t UA_LA     = 4'd6;
  localparam uaddr_t UA_LM     = 4'd7;
  localparam uaddr_t UA_LW     = 4'd8;
  localparam uaddr_t UA_SA     = 4'd9;
  localparam uaddr_t UA_SM     = 4'd10;
  localparam uaddr_t UA_BQ     = 4'd11;
  localparam uaddr_t UA_J1     = 4'd12;
  localparam uaddr_t UA_J2     = 4'd13;

  localparam opc_t OPC_REG  = 6'h00;
  localparam opc_t OPC_JMP  = 6'h02;
  localparam opc_t OPC_BEQ  = 6'h04;
  localparam opc_t OPC_ORI  = 6'h0D;
  localparam opc_t OPC_LOAD = 6'h23;
  localparam opc_t OPC_STOR = 6'h2B;

  localparam opc_t   DSP_OPC [N_DSP] = '{OPC_REG, OPC_ORI, OPC_LOAD, OPC_STOR, OPC_BEQ, OPC_JMP};
  localparam uaddr_t DSP_UA  [N_DSP] = '{UA_RX, UA_OX, UA_LA, UA_SA, UA_BQ, UA_J1};
endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  uaddr_t uaddr,
  output uword_t word
);
  always_comb begin
    word = '{alu_op: ALU_ADD, src_a: 1'b0, src_b: SB_FOUR, mem_op: MO_NONE,
             wb_sel: WB_NONE, pc_upd: PC_HOLD, ir_load: 1'b0, seq: SQ_RSVD};
    case (uaddr)
      UA_FETCH: begin
        word.mem_op = MO_FETCH; word.pc_upd = PC_ALU; word.ir_load = 1'b1; word.seq = SQ_INC;
      end
      UA_DECODE: begin
        word.src_b = SB_IMMSH; word.seq = SQ_DISP;
      end
      UA_RX: begin
        word.alu_op = ALU_FN; word.src_a = 1'b1; word.src_b = SB_REGB; word.seq = SQ_INC;
      end
      UA_RW: begin
        word.wb_sel = WB_ALU_RD; word.seq = SQ_FETCH;
      end
      UA_OX: begin
        word.alu_op = ALU_OR; word.src_a = 1'b1; word.src_b = SB_IMM; word.seq = SQ_INC;
      end
      UA_OW: begin
        word.wb_sel = WB_ALU_RT; word.seq = SQ_FETCH;
      end
      UA_LA, UA_SA: begin
        word.src_a = 1'b1; word.src_b = SB_IMM; word.seq = SQ_INC;
      end
      UA_LM: begin
        word.mem_op = MO_READ; word.seq = SQ_INC;
      end
      UA_LW: begin
        word.wb_sel = WB_MEM_RT; word.seq = SQ_FETCH;
      end
      UA_SM: begin
        word.mem_op = MO_WRITE; word.seq = SQ_FETCH;
      end
      UA_BQ: begin
        word.alu_op = ALU_SUB; word.src_a = 1'b1; word.src_b = SB_REGB;
        word.pc_upd = PC_COND; word.seq = SQ_FETCH;
      end
      UA_J1: begin
        word.src_b = SB_IMMSH; word.seq = SQ_INC;
      end
      UA_J2: begin
        word.pc_upd = PC_TGT; word.seq = SQ_FETCH;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
(
  input  opc_t   opcode,
  output uaddr_t target,
  output logic   hit
);
  logic [N_DSP-1:0] match;

  for (genvar g = 0; g < N_DSP; g++) begin : g_ent
    assign match[g] = (opcode == DSP_OPC[g]);
  end

  always_comb begin
    target = UA_FETCH;
    hit    = 1'b0;
    for (int i = 0; i < N_DSP; i++) begin
      if (match[i]) begin
        target = DSP_UA[i];
        hit    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  seq_e   seq,
  input  uaddr_t dsp_target,
  input  logic   dsp_hit,
  output uaddr_t upc
);
  uaddr_t upc_nxt;

  always_comb begin
    case (seq)
      SQ_INC:  upc_nxt = upc + 1'b1;
      SQ_DISP: upc_nxt = dsp_hit ? dsp_target : UA_FETCH;
      default: upc_nxt = UA_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= UA_FETCH;
    else        upc <= upc_nxt;
  end

  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UA_FETCH) |=> (upc == UA_DECODE));
  a_r9_miss_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SQ_DISP && !dsp_hit) |=> (upc == UA_FETCH));
  a_r10_hit_to_target: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SQ_DISP && dsp_hit) |=> (upc == $past(dsp_target)));
  a_r12_fetch_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SQ_FETCH || seq == SQ_RSVD) |=> (upc == UA_FETCH));
  a_r12_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == SQ_INC) |=> (upc == $past(upc) + 1'b1));
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output logic [1:0]      alu_op,
  output logic            alu_src_a,
  output logic [1:0]      alu_src_b,
  output logic [1:0]      mem_op,
  output logic [1:0]      wb_sel,
  output logic [1:0]      pc_upd,
  output logic            ir_load
);
  uaddr_t upc;
  uaddr_t dsp_target;
  logic   dsp_hit;
  uword_t word;

  useq_store u_store (.uaddr(upc), .word(word));

  useq_dispatch u_dsp (.opcode(opcode), .target(dsp_target), .hit(dsp_hit));

  useq_next u_next (
    .clk(clk), .rst_n(rst_n), .seq(word.seq),
    .dsp_target(dsp_target), .dsp_hit(dsp_hit), .upc(upc)
  );

  assign alu_op    = word.alu_op;
  assign alu_src_a = word.src_a;
  assign alu_src_b = word.src_b;
  assign mem_op    = word.mem_op;
  assign wb_sel    = word.wb_sel;
  assign pc_upd    = word.pc_upd;
  assign ir_load   = word.ir_load;

  a_r10_dispatch_in_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (word.seq == SQ_DISP) |-> (upc == UA_DECODE));
  a_r12_ir_with_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |-> (mem_op == 2'b01));
  a_r1_fetch_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ir_load && upc == UA_FETCH));
endmodule

// File: tb/useq_ctrl_bench.sv
`timescale 1ns/100ps
module useq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic [1:0] alu_op, alu_src_b, mem_op, wb_sel, pc_upd;
  logic       alu_src_a, ir_load;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  useq_ctrl u_useq_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .alu_op(alu_op), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
    .mem_op(mem_op), .wb_sel(wb_sel), .pc_upd(pc_upd), .ir_load(ir_load)
  );

  function automatic logic [11:0] mk(input logic [1:0] a, input logic sa, input logic [1:0] sb,
                                     input logic [1:0] m, input logic [1:0] w,
                                     input logic [1:0] p, input logic ir);
    return {a, sa, sb, m, w, p, ir};
  endfunction

  function automatic logic [11:0] now_word();
    return {alu_op, alu_src_a, alu_src_b, mem_op, wb_sel, pc_upd, ir_load};
  endfunction

  localparam logic [11:0] W_FETCH  = {2'b00, 1'b0, 2'b00, 2'b01, 2'b00, 2'b01, 1'b1};
  localparam logic [11:0] W_DECODE = {2'b00, 1'b0, 2'b11, 2'b00, 2'b00, 2'b00, 1'b0};

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Monitor: one expected word per falling edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [11:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, now_word(), e);
    end
  end

  task automatic push(input logic [11:0] w, input string t);
    exp_q.push_back(w);
    tag_q.push_back(t);
  endtask

  // Driver: called 1 ns after a rising edge with the fetch word current.
  task automatic run_instr(input logic [5:0] op, input string t, input bit swap, input logic [5:0] alt);
    int n;
    push(W_FETCH, "R2");
    push(W_DECODE, "R2");
    case (op)
      6'h00: begin push(mk(2'b10,1,2'b01,0,0,0,0), "R3"); push(mk(0,0,0,0,2'b01,0,0), "R3"); end
      6'h0D: begin push(mk(2'b11,1,2'b10,0,0,0,0), "R4"); push(mk(0,0,0,0,2'b10,0,0), "R4"); end
      6'h23: begin push(mk(2'b00,1,2'b10,0,0,0,0), t); push(mk(0,0,0,2'b10,0,0,0), t);
                   push(mk(0,0,0,0,2'b11,0,0), t); end
      6'h2B: begin push(mk(2'b00,1,2'b10,0,0,0,0), "R6"); push(mk(0,0,0,2'b11,0,0,0), "R6"); end
      6'h04: begin push(mk(2'b01,1,2'b01,0,0,2'b10,0), "R7"); end
      6'h02: begin push(mk(0,0,2'b11,0,0,0,0), "R8"); push(mk(0,0,0,0,0,2'b11,0), "R8"); end
      default: ;
    endcase
    n = exp_q.size();
    opcode = op;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (swap && i == 1) opcode = alt;
    end
    // Next instruction must start again with fetch: verified by next push.
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", now_word(), W_FETCH);
    @(posedge clk); #1;
    check("R1", now_word(), W_FETCH);
    rst_n = 1'b1;
    run_instr(6'h23, "R5", 0, 6'h00);
    run_instr(6'h2B, "R6", 0, 6'h00);
    run_instr(6'h00, "R3", 0, 6'h00);
    run_instr(6'h0D, "R4", 0, 6'h00);
    run_instr(6'h04, "R7", 0, 6'h00);
    run_instr(6'h02, "R8", 0, 6'h00);
    run_instr(6'h3F, "R9", 0, 6'h00);
    run_instr(6'h11, "R9", 0, 6'h00);
    // Opcode changed after decode: load sequence must continue (R10).
    run_instr(6'h23, "R10", 1, 6'h2B);
    run_instr(6'h04, "R7", 1, 6'h00);
    // Mid-sequence reset (R11): start a load, drop reset in its address step.
    push(W_FETCH, "R11");
    push(W_DECODE, "R11");
    opcode = 6'h23;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst_n = 1'b0;
    @(negedge clk);
    check("R11", now_word(), W_FETCH);
    @(posedge clk); #1;
    rst_n = 1'b1;
    check("R1", now_word(), W_FETCH);
    run_instr(6'h2B, "R6", 0, 6'h00);
    run_instr(6'h23, "R5", 0, 6'h00);
    @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12 actual=%0d expected=0 words left in queue", exp_q.size());
    end
    checks++;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule